// File: doc/BRIEF.md
# Control-Flow Redirect Unit

This unit sits beside the execute stage of a 32-bit MIPS-style core and resolves every branch and jump. Each cycle that the decoder presents an instruction with `in_valid` high, the unit compares the source register values, decides whether the program counter must be steered away from the sequential path, and forms the new program counter. For the linking forms it also raises a write-back request carrying the return address and the destination register index. Instructions it does not recognise are flagged instead of being acted on.

The program-counter input is the already incremented value used by the core: it points at the instruction after the delay slot. Relative branch targets are formed from it by adding the word-scaled immediate and taking back one word, so the result is relative to the delay-slot address. The same input value is the return address written by the linking forms. All results are captured in output registers one clock after the request.

The REGIMM group (opcode 0x01) is not decoded by exact rt values. Two rt bits steer it: bit 0 inverts the sign test, and bit 4 turns on linking.

Top module: `flow_redirect_unit`

## Requirements
- R1: After a synchronous reset, `out_valid`, `redirect`, `link_valid` and `unsupported` are all 0.
- R2: Opcode 0x04 redirects when `rs_val` equals `rt_val`. Opcode 0x05 redirects when they differ.
- R3: Opcode 0x06 redirects when `rs_val` as a signed value is zero or negative. Opcode 0x07 redirects when it is strictly positive.
- R4: Opcode 0x01 redirects when bit 31 of `rs_val` XOR bit 0 of `rt_idx` is 1. With bit 0 set, the test is "greater than or equal to zero".
- R5: Under opcode 0x01 with bit 4 of `rt_idx` set, a taken branch asserts `link_valid` with `link_reg` = 31 and `link_data` = `pc_in`. A branch that is not taken writes no link.
- R6: A taken relative branch sets `next_pc` = `pc_in` + (`imm_se` << 2) − 4, modulo 2^32.
- R7: Opcode 0x02 redirects to {`pc_in`[31:28], `jidx`, 2'b00}. Opcode 0x03 does the same and links `pc_in` into register 31.
- R8: Opcode 0x00 with `funct` 0x08 redirects to `rs_val` and does not link. With `funct` 0x09 it redirects to `rs_val` and links `pc_in` into register `rd_idx`.
- R9: A branch that is not taken gives `redirect` = 0, `next_pc` = `pc_in` and `link_valid` = 0.
- R10: Any opcode outside {0x00, 0x01 … 0x07}, or opcode 0x00 with a `funct` other than 0x08 or 0x09, gives `unsupported` = 1, `redirect` = 0, `link_valid` = 0 and `next_pc` = `pc_in`.
- R11: Results, with `out_valid` high, appear exactly one clock after `in_valid` is sampled high. A cycle with `in_valid` low produces `out_valid` = 0 and clears `redirect`, `link_valid` and `unsupported`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields below are valid this cycle |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field, used under opcode 0x00 |
| rt_idx | input | 5 | rt field; selects the REGIMM variant |
| rd_idx | input | 5 | rd field; link destination of the register jump |
| rs_val | input | 32 | Value of source register rs |
| rt_val | input | 32 | Value of source register rt |
| imm_se | input | 32 | Sign-extended 16-bit immediate |
| jidx | input | 26 | Absolute jump index |
| pc_in | input | 32 | Incremented program counter (address after the delay slot) |
| out_valid | output | 1 | Registered results below are valid |
| redirect | output | 1 | Control flow leaves the sequential path |
| next_pc | output | 32 | New program counter |
| link_valid | output | 1 | Return-address write-back request |
| link_reg | output | 5 | Write-back destination register |
| link_data | output | 32 | Return address to write |
| unsupported | output | 1 | Instruction not handled by this unit |

## Verification
A redirect and a return-address write land in the same output cycle for the REGIMM linking variants, the jump-and-link, and the register jump with link. The bench drives these with both taken and not-taken source values. A linking REGIMM branch that is not taken must drop both outputs together. Each scoreboard entry holds the expected `redirect`/`next_pc` pair and the expected `link_valid`/`link_reg`/`link_data` triple, and the whole entry is compared in the single cycle after issue. A target that is right but paired with a missing or misdirected link write therefore fails.

// File: rtl/fru_pkg.sv
package fru_pkg;
  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_REGIMM  = 6'h01;
  localparam logic [5:0] OPC_JUMP    = 6'h02;
  localparam logic [5:0] OPC_JLINK   = 6'h03;
  localparam logic [5:0] OPC_BREQ    = 6'h04;
  localparam logic [5:0] OPC_BRNE    = 6'h05;
  localparam logic [5:0] OPC_BRLEZ   = 6'h06;
  localparam logic [5:0] OPC_BRGTZ   = 6'h07;
  localparam logic [5:0] FN_REGJ     = 6'h08;
  localparam logic [5:0] FN_REGJL    = 6'h09;
  localparam logic [4:0] RA_INDEX    = 5'd31;

  typedef struct packed {
    logic       redir;
    logic       link;
    logic       unsup;
    logic [4:0] lidx;
  } decision_t;
endpackage

// File: rtl/fru_cond.sv
module fru_cond
  import fru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      opcode,
  input  logic [4:0]      rt_sel,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            taken,
  output logic            link_req
);
  logic same, is_zero, is_neg;

  always_comb begin
    same     = (rs_val == rt_val);
    is_zero  = (rs_val == '0);
    is_neg   = rs_val[XLEN-1];
    taken    = 1'b0;
    link_req = 1'b0;
    case (opcode)
      OPC_BREQ:   taken = same;
      OPC_BRNE:   taken = !same;
      OPC_BRLEZ:  taken = is_neg || is_zero;
      OPC_BRGTZ:  taken = !is_neg && !is_zero;
      OPC_REGIMM: begin
        // bit 0 flips the sign sense, bit 4 asks for a link
        taken    = is_neg ^ rt_sel[0];
        link_req = rt_sel[4] && (is_neg ^ rt_sel[0]);
      end
      default:    taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/fru_target.sv
module fru_target #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] imm_se,
  input  logic [XLEN-7:0] jidx,
  output logic [XLEN-1:0] br_target,
  output logic [XLEN-1:0] jmp_target
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  // pc_in already points past the delay slot; take one word back
  assign br_target  = pc_in + (imm_se << 2) - WORD;
  assign jmp_target = {pc_in[XLEN-1:XLEN-4], jidx, 2'b00};
endmodule

// File: rtl/flow_redirect_unit.sv
module flow_redirect_unit
  import fru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [5:0]      opcode,
  input  logic [5:0]      funct,
  input  logic [4:0]      rt_idx,
  input  logic [4:0]      rd_idx,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] imm_se,
  input  logic [XLEN-7:0] jidx,
  input  logic [XLEN-1:0] pc_in,
  output logic            out_valid,
  output logic            redirect,
  output logic [XLEN-1:0] next_pc,
  output logic            link_valid,
  output logic [4:0]      link_reg,
  output logic [XLEN-1:0] link_data,
  output logic            unsupported
);
  logic            cond_taken, cond_link;
  logic [XLEN-1:0] br_target, jmp_target, npc_d;
  decision_t       dec;

  fru_cond #(.XLEN(XLEN)) u_cond (
    .opcode   (opcode),
    .rt_sel   (rt_idx),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .taken    (cond_taken),
    .link_req (cond_link)
  );

  fru_target #(.XLEN(XLEN)) u_target (
    .pc_in      (pc_in),
    .imm_se     (imm_se),
    .jidx       (jidx),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  always_comb begin
    dec   = '{redir: 1'b0, link: 1'b0, unsup: 1'b0, lidx: RA_INDEX};
    npc_d = pc_in;
    case (opcode)
      OPC_SPECIAL: begin
        if (funct == FN_REGJ) begin
          dec.redir = 1'b1;
          npc_d     = rs_val;
        end else if (funct == FN_REGJL) begin
          dec.redir = 1'b1;
          dec.link  = 1'b1;
          dec.lidx  = rd_idx;
          npc_d     = rs_val;
        end else begin
          dec.unsup = 1'b1;
        end
      end
      OPC_REGIMM, OPC_BREQ, OPC_BRNE, OPC_BRLEZ, OPC_BRGTZ: begin
        dec.redir = cond_taken;
        dec.link  = cond_link;
        if (cond_taken) npc_d = br_target;
      end
      OPC_JUMP: begin
        dec.redir = 1'b1;
        npc_d     = jmp_target;
      end
      OPC_JLINK: begin
        dec.redir = 1'b1;
        dec.link  = 1'b1;
        npc_d     = jmp_target;
      end
      default: dec.unsup = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      redirect    <= 1'b0;
      link_valid  <= 1'b0;
      unsupported <= 1'b0;
      next_pc     <= '0;
      link_reg    <= '0;
      link_data   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        redirect    <= dec.redir;
        link_valid  <= dec.link;
        unsupported <= dec.unsup;
        next_pc     <= npc_d;
        link_reg    <= dec.lidx;
        link_data   <= pc_in;
      end else begin
        redirect    <= 1'b0;
        link_valid  <= 1'b0;
        unsupported <= 1'b0;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!out_valid && !redirect && !link_valid && !unsupported)); // R1

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R11

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && !redirect && !link_valid)); // R11

  AST_UNSUP_INERT: assert property (@(posedge clk) disable iff (rst) unsupported |-> (!redirect && !link_valid)); // R10

  AST_NE_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OPC_BREQ && rs_val != rt_val) |=> (!redirect && next_pc == $past(pc_in))); // R9

  AST_REGIMM_LINK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OPC_REGIMM && rt_idx[4] && (rs_val[XLEN-1] ^ rt_idx[0]))
      |=> (link_valid && link_reg == RA_INDEX && link_data == $past(pc_in))); // R5

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OPC_JUMP)
      |=> (redirect && next_pc == {$past(pc_in[XLEN-1:XLEN-4]), $past(jidx), 2'b00})); // R7
endmodule

// File: tb/flow_redirect_unit_tb.sv
`timescale 1ns/1ps
module flow_redirect_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  opcode = '0, funct = '0;
  logic [4:0]  rt_idx = '0, rd_idx = '0;
  logic [31:0] rs_val = '0, rt_val = '0, imm_se = '0, pc_in = '0;
  logic [25:0] jidx = '0;
  logic        out_valid, redirect, link_valid, unsupported;
  logic [31:0] next_pc, link_data;
  logic [4:0]  link_reg;

  always #2 clk = ~clk;

  flow_redirect_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .funct(funct),
    .rt_idx(rt_idx), .rd_idx(rd_idx), .rs_val(rs_val), .rt_val(rt_val),
    .imm_se(imm_se), .jidx(jidx), .pc_in(pc_in), .out_valid(out_valid),
    .redirect(redirect), .next_pc(next_pc), .link_valid(link_valid),
    .link_reg(link_reg), .link_data(link_data), .unsupported(unsupported)
  );

  typedef struct {
    logic        redir;
    logic [31:0] npc;
    logic        lnk;
    logic [4:0]  lreg;
    logic [31:0] ldata;
    logic        unsup;
    int          cyc;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, failures = 0, cyc = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  // monitor: pop and compare one entry per valid result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks = checks + 1;
      if (q.size() == 0) begin
        failures = failures + 1;
        $display("FAIL R11 unexpected result: got out_valid=1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (redirect !== e.redir || next_pc !== e.npc || link_valid !== e.lnk ||
            unsupported !== e.unsup || cyc != e.cyc + 1 ||
            (e.lnk && (link_reg !== e.lreg || link_data !== e.ldata))) begin
          failures = failures + 1;
          $display("FAIL %s: got redir=%0b npc=%08h lnk=%0b lreg=%0d ldata=%08h unsup=%0b cyc=%0d expected redir=%0b npc=%08h lnk=%0b lreg=%0d ldata=%08h unsup=%0b cyc=%0d",
                   e.req, redirect, next_pc, link_valid, link_reg, link_data, unsupported, cyc,
                   e.redir, e.npc, e.lnk, e.lreg, e.ldata, e.unsup, e.cyc + 1);
        end
      end
    end
  end

  task automatic send(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] rtf,
                      input logic [4:0] rdf, input logic [31:0] rs, input logic [31:0] rt,
                      input logic [31:0] imm, input logic [25:0] idx, input logic [31:0] pc,
                      input logic e_redir, input logic [31:0] e_npc, input logic e_lnk,
                      input logic [4:0] e_lreg, input logic e_unsup, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; opcode = op; funct = fn; rt_idx = rtf; rd_idx = rdf;
    rs_val = rs; rt_val = rt; imm_se = imm; jidx = idx; pc_in = pc;
    e.redir = e_redir; e.npc = e_npc; e.lnk = e_lnk; e.lreg = e_lreg; e.ldata = pc;
    e.unsup = e_unsup; e.cyc = cyc; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_quiet(input string req);
    checks = checks + 1;
    if (out_valid !== 1'b0 || redirect !== 1'b0 || link_valid !== 1'b0 || unsupported !== 1'b0) begin
      failures = failures + 1;
      $display("FAIL %s: got valid=%0b redir=%0b lnk=%0b unsup=%0b expected all 0",
               req, out_valid, redirect, link_valid, unsupported);
    end
  endtask

  localparam logic [31:0] PC = 32'h8000_1000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 reset state");

    send(6'h04, 0, 0, 0, 32'd5, 32'd5, 32'd4, 0, PC, 1, 32'h8000_100C, 0, 0, 0, "R2 R6 eq taken");
    send(6'h04, 0, 0, 0, 32'd5, 32'd6, 32'd4, 0, PC, 0, PC, 0, 0, 0, "R9 R2 eq not taken");
    send(6'h05, 0, 0, 0, 32'd1, 32'd2, 32'hFFFF_FFFF, 0, PC, 1, 32'h8000_0FF8, 0, 0, 0, "R2 R6 ne backward");
    send(6'h05, 0, 0, 0, 32'd9, 32'd9, 32'd4, 0, PC, 0, PC, 0, 0, 0, "R9 R2 ne not taken");
    send(6'h06, 0, 0, 0, 32'd0, 32'd0, 32'h10, 0, PC, 1, 32'h8000_103C, 0, 0, 0, "R3 lez zero");
    send(6'h06, 0, 0, 0, 32'h8000_0000, 32'd0, 32'h10, 0, PC, 1, 32'h8000_103C, 0, 0, 0, "R3 lez most negative");
    send(6'h06, 0, 0, 0, 32'd1, 32'd0, 32'h10, 0, PC, 0, PC, 0, 0, 0, "R3 lez positive");
    send(6'h07, 0, 0, 0, 32'd1, 32'd0, 32'h2, 0, PC, 1, 32'h8000_1004, 0, 0, 0, "R3 gtz one");
    send(6'h07, 0, 0, 0, 32'd0, 32'd0, 32'h2, 0, PC, 0, PC, 0, 0, 0, "R3 gtz zero");
    send(6'h07, 0, 0, 0, 32'hFFFF_FFFF, 32'd0, 32'h2, 0, PC, 0, PC, 0, 0, 0, "R3 gtz minus one");
    send(6'h01, 0, 5'd0, 0, 32'hFFFF_FFFB, 0, 32'd1, 0, PC, 1, PC, 0, 0, 0, "R4 ltz taken");
    send(6'h01, 0, 5'd0, 0, 32'd3, 0, 32'd1, 0, PC, 0, PC, 0, 0, 0, "R4 ltz not taken");
    send(6'h01, 0, 5'd1, 0, 32'd0, 0, 32'd3, 0, PC, 1, 32'h8000_1008, 0, 0, 0, "R4 gez zero");
    send(6'h01, 0, 5'd1, 0, 32'hFFFF_FFFF, 0, 32'd3, 0, PC, 0, PC, 0, 0, 0, "R4 gez negative");
    send(6'h01, 0, 5'd16, 0, 32'hFFFF_FFFF, 0, 32'd2, 0, PC, 1, 32'h8000_1004, 1, 5'd31, 0, "R5 ltz link taken");
    send(6'h01, 0, 5'd16, 0, 32'd7, 0, 32'd2, 0, PC, 0, PC, 0, 0, 0, "R5 ltz link not taken");
    send(6'h01, 0, 5'd17, 0, 32'd0, 0, 32'd2, 0, PC, 1, 32'h8000_1004, 1, 5'd31, 0, "R5 gez link taken");
    send(6'h02, 0, 0, 0, 0, 0, 0, 26'h012_3456, 32'h9ABC_0000, 1, 32'h9048_D158, 0, 0, 0, "R7 jump");
    send(6'h03, 0, 0, 0, 0, 0, 0, 26'h3FF_FFFF, 32'h1000_0004, 1, 32'h1FFF_FFFC, 1, 5'd31, 0, "R7 jump link");
    send(6'h00, 6'h08, 0, 5'd7, 32'h0040_0010, 0, 0, 0, PC, 1, 32'h0040_0010, 0, 0, 0, "R8 reg jump");
    send(6'h00, 6'h09, 0, 5'd7, 32'hBFC0_0100, 0, 0, 0, PC, 1, 32'hBFC0_0100, 1, 5'd7, 0, "R8 reg jump link");
    send(6'h00, 6'h20, 0, 5'd3, 32'd1, 32'd1, 0, 0, PC, 0, PC, 0, 0, 1, "R10 special other funct");
    send(6'h0F, 0, 0, 0, 32'd1, 32'd1, 0, 26'h1, PC, 0, PC, 0, 0, 1, "R10 unknown opcode");
    idle();
    @(negedge clk);
    check_quiet("R11 idle cycle");
    send(6'h23, 0, 0, 0, 32'd1, 32'd1, 0, 0, 32'h0000_0040, 0, 32'h0000_0040, 0, 0, 1, "R10 R11 after gap");
    idle();
    repeat (3) @(negedge clk);
    checks = checks + 1;
    if (q.size() != 0) begin
      failures = failures + 1;
      $display("FAIL R11 missing results: got %0d pending expected 0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule